// File: doc/BRIEF.md
# Line-Locked Feedback Divider

This block is the digital divider in the feedback path of a line-locked pixel clock loop. It runs on the recovered pixel clock and counts a programmable number of clocks for each video line. Once per line it emits a short active-high pulse, registered in the pixel clock domain, that serves as a clean stand-in for the horizontal sync. The phase comparator that steers the loop receives this pulse.

The line length is the programmed divide value plus a fixed offset of eight clocks. The counter wraps with no idle cycle. A divide value written partway through a line is adopted only at the next wrap. Two plain select inputs change the routing. The first sends the incoming sync to the pulse output in place of the divider pulse, after a two-flop synchronizer. The second lets an externally divided feedback signal reach the comparator in place of the internal pulse. The block has no streaming data path, so every pin is a plain level and no valid/ready handshake applies.

Top module: `line_feedback_divider`

## Requirements
- R1: While `rst` is sampled high, the line counter is cleared and `line_pulse_o` is driven low at the next clock edge. This also applies when reset arrives in the middle of a pulse.
- R2: With a constant `div_value` of N, successive rising edges of the divider pulse are exactly N + 8 clock cycles apart (N is 12 bits, 0 to 4095).
- R3: Every divider pulse is active high for exactly 4 consecutive clock cycles.
- R4: After `rst` is released, the divider pulse goes high on the first clock edge.
- R5: With `pulse_sel_ext` = 1, `line_pulse_o` equals `ext_sync_in` delayed by two clock edges. With `pulse_sel_ext` = 0, it carries the divider pulse.
- R6: With `fb_sel_ext` = 1, `fb_o` follows `ext_fb_in` with no clock delay. With `fb_sel_ext` = 0, `fb_o` equals the divider pulse.
- R7: The counter reloads on wrap with no gap cycle, so back-to-back lines keep the exact period at both the minimum (8) and the maximum (4103) length.
- R8: A change of `div_value` during a line leaves that line's length unchanged. The new length applies from the line that starts at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| div_value | input | 12 | Programmed divide value; the line length is this plus 8 |
| pulse_sel_ext | input | 1 | 1: the pulse output carries the synchronized input sync |
| fb_sel_ext | input | 1 | 1: the feedback output carries the external divider signal |
| ext_sync_in | input | 1 | Conditioned incoming horizontal sync, asynchronous |
| ext_fb_in | input | 1 | Feedback signal from an external divider |
| line_pulse_o | output | 1 | Recovered line pulse, or the synchronized input sync |
| fb_o | output | 1 | Feedback signal to the phase comparator |

## Verification
The assertions check the following on every cycle:
- the counter stays below the latched period and returns to zero right after its last count;
- the latched period holds steady between wraps;
- no pulse stays high longer than four cycles;
- reset forces the pulse low;
- the synchronizer output matches its input from two edges earlier.

Only the bench scenarios can show the following:
- the spacing of pulse edges in clock cycles for chosen divide values, including 0 and 4095;
- the one-line delay before a mid-line divide change takes effect;
- the cycle the first pulse appears after reset;
- the routing of both output multiplexers under each select setting.

// File: rtl/lfd_pkg.sv
package lfd_pkg;
  typedef enum logic {
    SRC_DIVIDER  = 1'b0,
    SRC_EXTERNAL = 1'b1
  } lfd_src_e;
endpackage

// File: rtl/lfd_sync.sv
module lfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= 1'b0;
    else     stage_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= 1'b0;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // Warm-up counter so the latency check only compares post-reset samples
  localparam int WW = $clog2(STAGES + 1);
  logic [WW-1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q != WW'(STAGES)) warm_q <= warm_q + 1'b1;
  end

  if (STAGES == 2) begin : g_chk2
    assert_sync_latency_R5: assert property (@(posedge clk) disable iff (rst)
      (warm_q == WW'(STAGES)) |-> (dout == $past(din, 2)));
  end
endmodule

// File: rtl/lfd_line_counter.sv
module lfd_line_counter #(
  parameter int DIV_W  = 12,
  parameter int OFFSET = 8,
  parameter int CNT_W  = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_value,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] period_next;
  logic             last_count;

  assign period_next = CNT_W'(div_value) + CNT_W'(OFFSET);
  assign last_count  = (cnt_q == (period_q - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      period_q <= period_next;
    end else if (last_count) begin
      cnt_q    <= '0;
      period_q <= period_next;
    end else begin
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < period_q);

  assert_reload_no_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == (period_q - CNT_W'(1))) |=> (cnt_q == '0));

  assert_period_held_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != (period_q - CNT_W'(1))) |=> $stable(period_q));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));
endmodule

// File: rtl/lfd_pulse_gen.sv
module lfd_pulse_gen #(
  parameter int CNT_W   = 13,
  parameter int PULSE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= (cnt_i < CNT_W'(PULSE_W));
  end

  assign pulse_o = pulse_q;

  // Number of cycles the pulse has already been high before this one
  localparam int RW = $clog2(PULSE_W + 2);
  logic [RW-1:0] hi_run_q;
  always_ff @(posedge clk) begin
    if (rst || !pulse_q) hi_run_q <= '0;
    else if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
  end

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (hi_run_q < RW'(PULSE_W)));

  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !pulse_q);
endmodule

// File: rtl/line_feedback_divider.sv
module line_feedback_divider #(
  parameter int DIV_W       = 12,
  parameter int OFFSET      = 8,
  parameter int PULSE_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_value,
  input  logic             pulse_sel_ext,
  input  logic             fb_sel_ext,
  input  logic             ext_sync_in,
  input  logic             ext_fb_in,
  output logic             line_pulse_o,
  output logic             fb_o
);
  import lfd_pkg::*;

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic             div_pulse;
  logic             sync_pulse;
  lfd_src_e         pulse_src;
  lfd_src_e         fb_src;

  lfd_line_counter #(
    .DIV_W (DIV_W),
    .OFFSET(OFFSET),
    .CNT_W (CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .div_value(div_value),
    .cnt_o    (cnt)
  );

  lfd_pulse_gen #(
    .CNT_W  (CNT_W),
    .PULSE_W(PULSE_W)
  ) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .cnt_i  (cnt),
    .pulse_o(div_pulse)
  );

  lfd_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (ext_sync_in),
    .dout(sync_pulse)
  );

  assign pulse_src = lfd_src_e'(pulse_sel_ext);
  assign fb_src    = lfd_src_e'(fb_sel_ext);

  always_comb begin
    line_pulse_o = (pulse_src == SRC_EXTERNAL) ? sync_pulse : div_pulse;
    fb_o         = (fb_src == SRC_EXTERNAL) ? ext_fb_in : div_pulse;
  end
endmodule

// File: tb/line_feedback_divider_bench.sv
module line_feedback_divider_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] div_value = 12'd0;
  logic        pulse_sel_ext = 1'b0;
  logic        fb_sel_ext = 1'b0;
  logic        ext_sync_in = 1'b0;
  logic        ext_fb_in = 1'b0;
  logic        line_pulse_o;
  logic        fb_o;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  line_feedback_divider u_line_feedback_divider (
    .clk(clk), .rst(rst), .div_value(div_value),
    .pulse_sel_ext(pulse_sel_ext), .fb_sel_ext(fb_sel_ext),
    .ext_sync_in(ext_sync_in), .ext_fb_in(ext_fb_in),
    .line_pulse_o(line_pulse_o), .fb_o(fb_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [11:0] dv);
    @(negedge clk);
    div_value = dv;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_rise(output int t);
    logic prev, cur;
    cur = line_pulse_o;
    do begin
      @(negedge clk);
      prev = cur;
      cur = line_pulse_o;
    end while (!(cur && !prev));
    t = cyc;
  endtask

  task automatic high_len(output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (!line_pulse_o) break;
      n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    div_value = 12'd12;
    repeat (3) @(negedge clk);
    chk("R1 pulse low in reset", line_pulse_o, 0);
    chk("R6 fb_o follows divider in reset", fb_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 first pulse after release", line_pulse_o, 1);
    begin
      int n;
      high_len(n);
      chk("R3 first pulse width", n, 4);
    end
  endtask

  task automatic t_period(input logic [11:0] dv);
    int r0, r1, r2, n;
    do_reset(dv);
    wait_rise(r0);
    high_len(n);
    chk("R3 pulse width", n, 4);
    wait_rise(r1);
    wait_rise(r2);
    chk("R2 line period", r1 - r0, int'(dv) + 8);
    chk("R7 back-to-back period", r2 - r1, int'(dv) + 8);
  endtask

  task automatic t_midchange();
    int r0, r1, r2;
    do_reset(12'd20);
    wait_rise(r0);
    repeat (10) @(negedge clk);
    div_value = 12'd50;
    wait_rise(r1);
    wait_rise(r2);
    chk("R8 current line keeps old length", r1 - r0, 28);
    chk("R8 next line uses new length", r2 - r1, 58);
  endtask

  task automatic t_midreset();
    int r0;
    do_reset(12'd30);
    wait_rise(r0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-pulse drives low", line_pulse_o, 0);
    rst = 1'b0;
  endtask

  task automatic t_sync_path();
    int r0, r1;
    do_reset(12'd40);
    pulse_sel_ext = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 sync path idle low", line_pulse_o, 0);
    ext_sync_in = 1'b1;
    @(negedge clk);
    chk("R5 one edge after input rise", line_pulse_o, 0);
    @(negedge clk);
    chk("R5 two edges after input rise", line_pulse_o, 1);
    ext_sync_in = 1'b0;
    @(negedge clk);
    chk("R5 one edge after input fall", line_pulse_o, 1);
    @(negedge clk);
    chk("R5 two edges after input fall", line_pulse_o, 0);
    pulse_sel_ext = 1'b0;
    wait_rise(r0);
    wait_rise(r1);
    chk("R5 divider pulse restored", r1 - r0, 48);
  endtask

  task automatic t_fb_path();
    do_reset(12'd9);
    fb_sel_ext = 1'b1;
    ext_fb_in = 1'b1;
    #1;
    chk("R6 external feedback high", fb_o, 1);
    ext_fb_in = 1'b0;
    #1;
    chk("R6 external feedback low", fb_o, 0);
    fb_sel_ext = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R6 internal feedback equals pulse", fb_o, line_pulse_o);
    end
  endtask

  initial begin
    t_reset();
    t_period(12'd0);
    t_period(12'd5);
    t_period(12'd100);
    t_period(12'd4095);
    t_midchange();
    t_midreset();
    t_sync_path();
    t_fb_path();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule